// File: doc/BRIEF.md
# Single-Cycle Past-Time Temporal Property Monitor

This block watches a stream of serialized events and, for every event, decides whether one fixed past-time temporal property still holds. Six events are watched, in three pairs: the data converter being switched on and off, its clock source being reported good and bad, and a counter being started and stopped. For each pair, one flip-flop holds whether the "on" event has happened more recently than the "off" event. This is the "on-side since off-side" term, and it is true when the start event arrives now, or when the stop event is absent now and the term was already true at the previous event.

The property is: when the converter is on and its clock source is good, the counter must be running. Each accepted event updates all three terms together through flattened next-state equations. The verdict is built from the freshly updated terms, so one event is handled completely in one clock. An upstream event serializer feeds the block one event code per cycle. A downstream recovery engine consumes the one-cycle verdict pulses.

Top module: `ptlPastMonitor`

## Requirements
- R1: After reset all three terms are false, `verdict` is 0 and `protoErr` is 0. For example, a first accepted clock-good event yields a true verdict, because the converter term is still false.
- R2: A term changes only on a cycle where an event is accepted. With `evValid` low, the code bits have no effect on later verdicts.
- R3: Each term is set by its start event and cleared by its stop event, and keeps its value on all other events. Event code bit positions: 0 converter on, 1 converter off, 2 clock good, 3 clock bad, 4 counter start, 5 counter stop.
- R4: An event is accepted when `evValid` is high and `evCode` has exactly one bit set. In the cycle after an accepted event, `verdict` is 1 if the property holds and 2 if it fails. The verdict is judged on the updated terms, so a counter-start event always yields 1.
- R5: In a cycle that does not follow an accepted event, `verdict` is 0. Each verdict lasts exactly one cycle.
- R6: When `evValid` is high and `evCode` has zero or several bits set, `protoErr` rises in the next cycle. It stays high until reset.
- R7: A rejected code leaves all three terms unchanged and gives verdict 0 in the next cycle.
- R8: Events accepted in consecutive cycles each produce their own verdict, one cycle apart, with no event lost or merged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | An event code is presented this cycle |
| evCode | input | 6 | One-hot event code, bit map as in R3 |
| verdict | output | 2 | 0 no event, 1 property holds, 2 property fails |
| protoErr | output | 1 | Sticky flag for a malformed event code |

## Verification
Two functions can coincide in one cycle: a term's update and the verdict that depends on it. A back-to-back run of events is driven in which a start or stop event flips the decisive term in the same cycle the verdict is formed, for example a counter stop while the converter is on and the clock is good. A stale read would show up as the wrong verdict. A reference model updates its terms first and only then evaluates the property, and a scoreboard compares its result against every verdict pulse. Malformed codes are interleaved to confirm that rejection and the sticky flag never disturb the terms.

// File: rtl/ptlMonPkg.sv
package ptlMonPkg;
  localparam int NUM_SUB = 3;
  localparam int NUM_EV  = 2 * NUM_SUB;

  localparam int SUB_CONV = 0;
  localparam int SUB_SRC  = 1;
  localparam int SUB_CNT  = 2;

  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_TRUE  = 2'd1,
    VERD_FALSE = 2'd2
  } verdict_e;

  typedef struct packed {
    logic update;
    logic badCode;
  } ctrlStrobe_t;
endpackage

// File: rtl/ptlMonCtrl.sv
module ptlMonCtrl
  import ptlMonPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic [NUM_EV-1:0] evCode,
  output ctrlStrobe_t       strobe,
  output logic              protoErr
);
  logic oneHot;
  logic errQ;

  assign oneHot        = $onehot(evCode);
  assign strobe.update  = evValid & oneHot;
  assign strobe.badCode = evValid & ~oneHot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else if (strobe.badCode) errQ <= 1'b1;
  end

  assign protoErr = errQ;

  // R6: once raised the flag never drops
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
  // R6: malformed code raises the flag
  a_r6_err_set: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && $countones(evCode) != 1) |=> protoErr);
  // R4: accept and reject never coincide
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.update && strobe.badCode));
endmodule

// File: rtl/ptlMonData.sv
module ptlMonData
  import ptlMonPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [NUM_EV-1:0] evCode,
  output verdict_e          verdict
);
  logic [NUM_SUB-1:0] sinceQ;
  logic [NUM_SUB-1:0] sinceNext;
  logic               propHolds;
  verdict_e           verdictQ;

  // Flattened "not stop since start" update, one per term
  for (genvar i = 0; i < NUM_SUB; i++) begin : g_since
    assign sinceNext[i] = evCode[2*i] | (~evCode[2*i+1] & sinceQ[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sinceQ[i] <= 1'b0;
      else if (strobe.update) sinceQ[i] <= sinceNext[i];
    end
  end

  // Verdict judged on the freshly computed terms
  assign propHolds = ~(sinceNext[SUB_CONV] & sinceNext[SUB_SRC]) | sinceNext[SUB_CNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) verdictQ <= VERD_NONE;
    else if (strobe.update) verdictQ <= propHolds ? VERD_TRUE : VERD_FALSE;
    else verdictQ <= VERD_NONE;
  end

  assign verdict = verdictQ;

  // R2: terms hold when nothing is accepted
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.update |=> $stable(sinceQ));
  // R5: no verdict without an accepted event
  a_r5_idle_verdict: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.update |=> verdict == VERD_NONE);
  // R4: an accepted event always yields a verdict
  a_r4_verdict_given: assert property (@(posedge clk) disable iff (!rstN)
    strobe.update |=> verdict != VERD_NONE);
  // R4: a counter start must give a true verdict
  a_r4_cnt_fresh: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.update && evCode[2*SUB_CNT]) |=> verdict == VERD_TRUE);
  // R3: a converter stop clears its term
  a_r3_conv_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.update && evCode[2*SUB_CONV+1]) |=> !sinceQ[SUB_CONV]);
  // R3: a clock-good event sets its term
  a_r3_src_set: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.update && evCode[2*SUB_SRC]) |=> sinceQ[SUB_SRC]);
endmodule

// File: rtl/ptlPastMonitor.sv
module ptlPastMonitor
  import ptlMonPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic [NUM_EV-1:0] evCode,
  output logic [1:0]        verdict,
  output logic              protoErr
);
  ctrlStrobe_t strobe;
  verdict_e    verdictInt;

  ptlMonCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evValid  (evValid),
    .evCode   (evCode),
    .strobe   (strobe),
    .protoErr (protoErr)
  );

  ptlMonData u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .evCode  (evCode),
    .verdict (verdictInt)
  );

  assign verdict = verdictInt;

  // R7: a rejected code produces no verdict
  a_r7_reject_silent: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && $countones(evCode) != 1) |=> verdict == 2'd0);
  // R4: the verdict code is never 3
  a_r4_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    verdict != 2'd3);
endmodule

// File: tb/ptlPastMonitor_tb.sv
module ptlPastMonitor_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evValid = 1'b0;
  logic [5:0] evCode = '0;
  logic [1:0] verdict;
  logic       protoErr;

  int nChecks = 0;
  int nFails  = 0;

  logic [1:0] expVerdQ[$];
  logic       expErrQ[$];
  string      tagQ[$];

  logic mConv = 1'b0, mSrc = 1'b0, mCnt = 1'b0, mErr = 1'b0;

  localparam logic [5:0] CONV_ON  = 6'b000001;
  localparam logic [5:0] CONV_OFF = 6'b000010;
  localparam logic [5:0] SRC_OK   = 6'b000100;
  localparam logic [5:0] SRC_BAD  = 6'b001000;
  localparam logic [5:0] CNT_ON   = 6'b010000;
  localparam logic [5:0] CNT_OFF  = 6'b100000;

  ptlPastMonitor u_dut (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evCode(evCode),
    .verdict(verdict), .protoErr(protoErr)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sendEvent(input logic [5:0] code, input string tag);
    logic [1:0] e;
    @(negedge clk);
    evValid = 1'b1;
    evCode  = code;
    if ($countones(code) == 1) begin
      if (code[0]) mConv = 1'b1;
      if (code[1]) mConv = 1'b0;
      if (code[2]) mSrc  = 1'b1;
      if (code[3]) mSrc  = 1'b0;
      if (code[4]) mCnt  = 1'b1;
      if (code[5]) mCnt  = 1'b0;
      e = (mConv && mSrc && !mCnt) ? 2'd2 : 2'd1;
    end else begin
      mErr = 1'b1;
      e = 2'd0;
    end
    expVerdQ.push_back(e);
    expErrQ.push_back(mErr);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n, input logic [5:0] junk, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evValid = 1'b0;
      evCode  = junk;
      expVerdQ.push_back(2'd0);
      expErrQ.push_back(mErr);
      tagQ.push_back(tag);
    end
  endtask

  // Monitor: pops one expected item per cycle
  always @(posedge clk) begin
    #2;
    if (expVerdQ.size() > 0) begin
      logic [1:0] ev;
      logic       ee;
      string      t;
      ev = expVerdQ.pop_front();
      ee = expErrQ.pop_front();
      t  = tagQ.pop_front();
      check({t, " verdict"}, verdict, ev);
      check("R6 protoErr", {1'b0, protoErr}, {1'b0, ee});
    end
  end

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset verdict", verdict, 2'd0);
    check("R1 reset protoErr", {1'b0, protoErr}, 2'd0);
    rstN = 1'b1;
    idle(2, 6'b000000, "R5");
    sendEvent(SRC_OK,   "R1");
    sendEvent(CONV_ON,  "R4");
    sendEvent(CNT_ON,   "R4");
    sendEvent(SRC_OK,   "R3");
    sendEvent(CNT_OFF,  "R4");
    sendEvent(SRC_BAD,  "R3");
    idle(1, 6'b000000, "R5");
    sendEvent(CONV_OFF, "R8");
    sendEvent(CNT_ON,   "R8");
    sendEvent(SRC_OK,   "R8");
    sendEvent(CONV_ON,  "R8");
    sendEvent(CNT_OFF,  "R8");
    idle(1, 6'b000000, "R5");
    sendEvent(6'b010010, "R7");
    sendEvent(6'b000000, "R7");
    sendEvent(SRC_OK,   "R7");
    idle(2, CNT_ON, "R2");
    sendEvent(SRC_OK,   "R2");
    sendEvent(CNT_ON,   "R3");
    sendEvent(SRC_BAD,  "R3");
    sendEvent(CNT_OFF,  "R3");
    sendEvent(SRC_OK,   "R4");
    sendEvent(6'b111111, "R6");
    idle(1, 6'b000000, "R6");
    for (int k = 0; k < 24; k++) begin
      sendEvent(6'b000001 << (k % 6), "R8");
    end
    idle(3, 6'b000000, "R5");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule